// File: doc/BRIEF.md
# Idle Power-Down Timer

This block decides when one peripheral may go to sleep. Software loads an 8-bit idle count through an index/data style write port. Each time the peripheral sees activity (a host access, an interrupt request or an external input event), the block wakes it and reloads a down-counter from that count. While the peripheral is working, the counter steps down once per time unit. When the counter runs out, the block raises a registered sleep flag.

The time unit is one second or one minute, picked by a select input. Both units come from a prescaler that runs on the base clock, followed by a divide-by-minute stage. A count of zero turns the automatic power-down off and holds the present working or sleeping state. The timer acts only while a chip-wide enable and a per-device enable are both high. If either enable is low, the device is held awake and the counter is frozen.

Top module: `idlepd_ctrl`

## Requirements
- R1: After reset, `sleep` is 0, `count` is 0 and the idle count register holds 00h.
- R2: A write changes the idle count register only when `cfg_wr` and `cfg_ext_mode` are both 1 and `cfg_index` equals `REG_INDEX` (default 37h). Any other write has no effect.
- R3: Any of `act_host`, `act_irq` or `act_ext` is activity. When activity arrives while both enables are set and the register value is nonzero, the next cycle shows `sleep` at 0 and `count` equal to the register value.
- R4: While working, enabled and with a nonzero register, `count` drops by one on each time-unit tick. A tick that finds `count` at 1 or 0 sets `count` to 0 and raises `sleep` in the same cycle.
- R5: While sleeping, `count` stays 0 and ticks have no effect. `sleep` stays at 1 until activity arrives or an enable is cleared.
- R6: While the register holds 00h, the working/sleeping state does not change, even when activity arrives.
- R7: With `unit_min` at 0, one tick occurs every `CLKS_PER_SEC` clocks. With `unit_min` at 1, one tick occurs every `SECS_PER_MIN` seconds.
- R8: While `pm_chip_en` or `pm_dev_en` is 0, `sleep` is 0 from the next cycle on and `count` holds its value. Writes still update the register but do not load the counter.
- R9: When activity and a tick fall in the same cycle, the reload wins: `count` takes the register value and is not decremented.
- R10: A register write while working and enabled also loads `count` with the written value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ext_mode | input | 1 | Extended configuration mode active |
| cfg_index | input | 8 | Currently selected configuration index |
| cfg_wdata | input | 8 | Write data for the selected register |
| act_host | input | 1 | Host access to the peripheral |
| act_irq | input | 1 | Peripheral interrupt request |
| act_ext | input | 1 | External input event |
| pm_chip_en | input | 1 | Chip-wide power-management enable |
| pm_dev_en | input | 1 | Per-device power-management enable |
| unit_min | input | 1 | Tick unit: 0 = second, 1 = minute |
| sleep | output | 1 | Registered sleep indicator |
| count | output | 8 | Current idle down-counter value |

## Verification
The counter value is visible at the ports, so a wrong reload source or a missing decrement shows on `count` one clock after the activity or tick that caused it. A wrong working/sleeping state shows on `sleep` at the tick edge that empties the counter, or one clock after a wake event. That edge falls within a known window of whole ticks after a reload. A broken prescaler or minute divider moves that sleep edge outside the window for its unit. A wrong priority between reload and tick leaves `count` one lower right after an aligned activity pulse.

// File: rtl/idlepd_pkg.sv
package idlepd_pkg;
  typedef enum logic {
    PD_WORK  = 1'b0,
    PD_SLEEP = 1'b1
  } pd_state_e;
endpackage

// File: rtl/idlepd_tick_gen.sv
module idlepd_tick_gen #(
  parameter int CLKS_PER_SEC = 32768,
  parameter int SECS_PER_MIN = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic unit_min,
  output logic tick
);
  localparam int PW = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
  localparam int MW = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_SEC - 1);
  localparam logic [MW-1:0] MIN_LAST = MW'(SECS_PER_MIN - 1);

  logic [PW-1:0] pre_q, pre_n;
  logic [MW-1:0] min_q, min_n;
  logic          sec_tick, min_tick;

  // seconds prescaler and minute divider
  always_comb begin
    sec_tick = (pre_q == PRE_LAST);
    min_tick = sec_tick && (min_q == MIN_LAST);
    pre_n    = sec_tick ? '0 : pre_q + 1'b1;
    min_n    = min_q;
    if (sec_tick) begin
      min_n = (min_q == MIN_LAST) ? '0 : min_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      min_q <= '0;
    end else begin
      pre_q <= pre_n;
      min_q <= min_n;
    end
  end

  assign tick = unit_min ? min_tick : sec_tick;
endmodule

// File: rtl/idlepd_cfg_reg.sv
module idlepd_cfg_reg #(
  parameter int                IDX_W     = 8,
  parameter int                CNT_W     = 8,
  parameter logic [IDX_W-1:0]  REG_INDEX = 8'h37
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_ext_mode,
  input  logic [IDX_W-1:0] cfg_index,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic             wr_hit,
  output logic [CNT_W-1:0] reg_q
);
  logic [CNT_W-1:0] reg_n;

  always_comb begin
    wr_hit = cfg_wr && cfg_ext_mode && (cfg_index == REG_INDEX);
    reg_n  = wr_hit ? cfg_wdata : reg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= '0;
    end else if (wr_hit) begin
      reg_q <= reg_n;
    end
  end
endmodule

// File: rtl/idlepd_fsm.sv
module idlepd_fsm
  import idlepd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             activity,
  input  logic             wr_hit,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] reg_q,
  input  logic             tick,
  output pd_state_e        st_q,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  pd_state_e        st_n;
  logic [CNT_W-1:0] cnt_n;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    load_val = wr_hit ? wdata : reg_q;
    st_n     = st_q;
    cnt_n    = cnt_q;
    if (!en) begin
      st_n = PD_WORK;
    end else if (activity) begin
      cnt_n = load_val;
      if (load_val != '0) st_n = PD_WORK;
    end else if (wr_hit) begin
      if (st_q == PD_WORK) cnt_n = wdata;
    end else if (st_q == PD_WORK && tick && reg_q != '0) begin
      if (cnt_q <= ONE) begin
        cnt_n = '0;
        st_n  = PD_SLEEP;
      end else begin
        cnt_n = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PD_WORK;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/idlepd_ctrl.sv
module idlepd_ctrl
  import idlepd_pkg::*;
#(
  parameter int          CLKS_PER_SEC = 32768,
  parameter int          SECS_PER_MIN = 60,
  parameter logic [7:0]  REG_INDEX    = 8'h37
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic       cfg_ext_mode,
  input  logic [7:0] cfg_index,
  input  logic [7:0] cfg_wdata,
  input  logic       act_host,
  input  logic       act_irq,
  input  logic       act_ext,
  input  logic       pm_chip_en,
  input  logic       pm_dev_en,
  input  logic       unit_min,
  output logic       sleep,
  output logic [7:0] count
);
  localparam int CNT_W = 8;

  logic             tick;
  logic             wr_hit;
  logic [CNT_W-1:0] reg_q;
  logic             en;
  logic             activity;
  pd_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;

  assign en       = pm_chip_en & pm_dev_en;
  assign activity = act_host | act_irq | act_ext;

  idlepd_tick_gen #(
    .CLKS_PER_SEC(CLKS_PER_SEC),
    .SECS_PER_MIN(SECS_PER_MIN)
  ) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .unit_min (unit_min),
    .tick     (tick)
  );

  idlepd_cfg_reg #(
    .IDX_W     (8),
    .CNT_W     (CNT_W),
    .REG_INDEX (REG_INDEX)
  ) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_ext_mode (cfg_ext_mode),
    .cfg_index    (cfg_index),
    .cfg_wdata    (cfg_wdata),
    .wr_hit       (wr_hit),
    .reg_q        (reg_q)
  );

  idlepd_fsm #(
    .CNT_W(CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .activity (activity),
    .wr_hit   (wr_hit),
    .wdata    (cfg_wdata),
    .reg_q    (reg_q),
    .tick     (tick),
    .st_q     (st_q),
    .cnt_q    (cnt_q)
  );

  assign sleep = (st_q == PD_SLEEP);
  assign count = cnt_q;
endmodule

// File: rtl/idlepd_ctrl_chk.sv
module idlepd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pm_chip_en,
  input logic       pm_dev_en,
  input logic       act_host,
  input logic       act_irq,
  input logic       act_ext,
  input logic       wr_hit,
  input logic [7:0] reg_q,
  input logic       sleep,
  input logic [7:0] count
);
  logic en_c, act_c;
  assign en_c  = pm_chip_en && pm_dev_en;
  assign act_c = act_host || act_irq || act_ext;

  // R5: a sleeping device always shows an empty counter
  p_sleep_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> count == 8'd0);

  // R8: disabled means awake on the next cycle
  p_disabled_awake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_c |=> !sleep);

  // R8: disabled means the counter is frozen
  p_disabled_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_c |=> count == $past(count));

  // R3: activity with a nonzero register wakes and reloads
  p_wake_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_c && act_c && !wr_hit && reg_q != 8'd0) |=> (!sleep && count == $past(reg_q)));

  // R6: zero register freezes the state
  p_zero_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_c && reg_q == 8'd0 && !wr_hit) |=> sleep == $past(sleep));

  // R4: without reload sources the counter only holds or steps down by one
  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_c && !act_c && !wr_hit) |=>
      (count == $past(count) || count == 8'($past(count) - 8'd1)));
endmodule

bind idlepd_ctrl idlepd_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pm_chip_en (pm_chip_en),
  .pm_dev_en  (pm_dev_en),
  .act_host   (act_host),
  .act_irq    (act_irq),
  .act_ext    (act_ext),
  .wr_hit     (wr_hit),
  .reg_q      (reg_q),
  .sleep      (sleep),
  .count      (count)
);

// File: tb/idlepd_ctrl_tb.sv
module idlepd_ctrl_tb;
  localparam int CPS = 4;
  localparam int SPM = 3;

  logic       clk;
  logic       rst_n;
  logic       cfg_wr, cfg_ext_mode;
  logic [7:0] cfg_index, cfg_wdata;
  logic       act_host, act_irq, act_ext;
  logic       pm_chip_en, pm_dev_en, unit_min;
  logic       sleep;
  logic [7:0] count;

  idlepd_ctrl #(
    .CLKS_PER_SEC(CPS),
    .SECS_PER_MIN(SPM),
    .REG_INDEX(8'h37)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ext_mode(cfg_ext_mode),
    .cfg_index(cfg_index), .cfg_wdata(cfg_wdata), .act_host(act_host),
    .act_irq(act_irq), .act_ext(act_ext), .pm_chip_en(pm_chip_en),
    .pm_dev_en(pm_dev_en), .unit_min(unit_min), .sleep(sleep), .count(count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    string      tag;
    logic       exp_sleep;
    logic [7:0] exp_cnt;
  } exp_item_t;

  exp_item_t sb_q[$];
  event      sb_ev;
  int        n_cmp = 0;
  int        n_bad = 0;
  bit        finished = 0;

  // scoreboard monitor: compares queued expectations with the outputs
  always @(sb_ev) begin
    while (sb_q.size() > 0) begin
      exp_item_t it;
      it = sb_q.pop_front();
      n_cmp++;
      if (sleep !== it.exp_sleep || count !== it.exp_cnt) begin
        n_bad++;
        $display("FAIL %s: sleep=%0b count=%0d expected sleep=%0b count=%0d",
                 it.tag, sleep, count, it.exp_sleep, it.exp_cnt);
      end
    end
  end

  task automatic expect_out(input string tag, input logic s, input logic [7:0] c);
    exp_item_t it;
    it.tag = tag; it.exp_sleep = s; it.exp_cnt = c;
    sb_q.push_back(it);
    ->sb_ev;
    #1;
  endtask

  task automatic chk_range(input string tag, input int act, input int lo, input int hi);
    n_cmp++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: edges=%0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic ext, input logic [7:0] idx, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_ext_mode = ext; cfg_index = idx; cfg_wdata = d;
    step(1);
    cfg_wr = 1'b0; cfg_ext_mode = 1'b0;
  endtask

  task automatic pulse(input int which);
    act_host = (which == 0); act_irq = (which == 1); act_ext = (which == 2);
    step(1);
    act_host = 1'b0; act_irq = 1'b0; act_ext = 1'b0;
  endtask

  task automatic edges_to_sleep(output int n);
    n = 0;
    while (!sleep && n < 300) begin
      step(1);
      n++;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] prev;
    rst_n = 1'b0; cfg_wr = 0; cfg_ext_mode = 0; cfg_index = 0; cfg_wdata = 0;
    act_host = 0; act_irq = 0; act_ext = 0; pm_chip_en = 0; pm_dev_en = 0; unit_min = 0;
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_out("R1 reset", 1'b0, 8'd0);

    pm_chip_en = 1; pm_dev_en = 1;
    cfg_write(1'b1, 8'h37, 8'd5);
    expect_out("R10 write reload", 1'b0, 8'd5);

    cfg_write(1'b1, 8'h38, 8'd9);
    cfg_write(1'b0, 8'h37, 8'd9);
    pulse(0);
    expect_out("R2 unselected writes ignored", 1'b0, 8'd5);

    edges_to_sleep(n);
    chk_range("R4 R7 seconds window", n, 4 * CPS + 1, 5 * CPS);
    expect_out("R4 sleep count zero", 1'b1, 8'd0);

    step(25);
    expect_out("R5 sleep holds", 1'b1, 8'd0);

    pulse(1);
    expect_out("R3 irq wakes", 1'b0, 8'd5);
    edges_to_sleep(n);
    pulse(2);
    expect_out("R3 ext wakes", 1'b0, 8'd5);

    // R9: align a host pulse with a tick edge
    prev = count;
    n = 0;
    while (count == prev && n < 50) begin step(1); n++; end
    step(CPS - 1);
    pulse(0);
    expect_out("R9 reload beats tick", 1'b0, 8'd5);

    unit_min = 1;
    cfg_write(1'b1, 8'h37, 8'd2);
    expect_out("R10 write reload 2", 1'b0, 8'd2);
    edges_to_sleep(n);
    chk_range("R7 minute window", n, CPS * SPM + 1, 2 * CPS * SPM);
    unit_min = 0;

    cfg_write(1'b1, 8'h37, 8'd0);
    pulse(0);
    expect_out("R6 zero keeps sleeping", 1'b1, 8'd0);
    step(30);
    expect_out("R6 still sleeping", 1'b1, 8'd0);
    cfg_write(1'b1, 8'h37, 8'd3);
    expect_out("R5 write while sleeping no reload", 1'b1, 8'd0);
    pulse(0);
    expect_out("R3 wake reg 3", 1'b0, 8'd3);
    cfg_write(1'b1, 8'h37, 8'd0);
    expect_out("R10 write zero", 1'b0, 8'd0);
    step(40);
    expect_out("R6 zero keeps working", 1'b0, 8'd0);

    cfg_write(1'b1, 8'h37, 8'd4);
    pulse(0);
    expect_out("R3 wake reg 4", 1'b0, 8'd4);
    edges_to_sleep(n);
    pm_dev_en = 0;
    step(1);
    expect_out("R8 device disable wakes", 1'b0, 8'd0);
    step(30);
    expect_out("R8 disabled stays awake", 1'b0, 8'd0);
    pulse(0);
    expect_out("R8 activity no load while disabled", 1'b0, 8'd0);
    cfg_write(1'b1, 8'h37, 8'd7);
    expect_out("R8 write no load while disabled", 1'b0, 8'd0);
    pm_dev_en = 1;
    pulse(0);
    expect_out("R8 register updated while disabled", 1'b0, 8'd7);
    prev = count;
    n = 0;
    while (count == prev && n < 50) begin step(1); n++; end
    pm_chip_en = 0;
    step(1);
    expect_out("R8 chip disable holds count", 1'b0, 8'd6);
    step(30);
    expect_out("R8 chip disable frozen", 1'b0, 8'd6);

    step(2);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule